// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register memory transfer. A command names up to sixteen registers through a bit list, a base address, a direction (load or store), pre- or post-indexing, an ascending or descending address step, and whether the base is written back. The sequencer walks the selected registers one at a time and issues one 32-bit memory request per register over a request/ready handshake. For a store it names the register it needs and forwards that register's value as write data. For a load it returns each word together with its register index.

The block also reports each new base value that has to be written back. When register 15 is loaded it raises a branch request that carries the loaded word. The register file and the memory are outside the block. A post-indexed command that also asks for writeback is an illegal combination. The block flags it and still runs the transfer.

The state machine has three states. `ST_IDLE` waits for a start pulse. `ST_MOVE` issues requests. `ST_DONE` gives the one-cycle completion pulse. The transitions are:

- IDLE→MOVE: a start pulse arrives with a non-empty list.
- IDLE→DONE: a start pulse arrives with an empty list.
- MOVE→MOVE: a handshake completes and registers remain, or ready is still low.
- MOVE→DONE: the handshake for the last register completes.
- DONE→IDLE: always, on the next edge.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o`, `err_o`, `ld_we_o` and `wb_valid_o` are all low.
- R2: An accepted start pulse makes `busy_o` high from the next cycle up to and including the `done_o` cycle. `done_o` lasts one cycle. A start pulse while `busy_o` is high has no effect on the transfer.
- R3: An empty register list produces no memory request. `done_o` comes in the cycle right after the start pulse.
- R4: Exactly one request is issued for each set list bit, and clear bits are skipped. A load visits registers from index 15 down to 0. A store visits them from 0 up to 15.
- R5: Consecutive accesses step the address by +4 when `up_i`=1 and by −4 when `up_i`=0.
- R6: With `pre_i`=1, the first access is at base±4. If `wb_en_i`=1, each handshake reports `wb_valid_o` with `wb_value_o` equal to that access address. If `wb_en_i`=0, no writeback is reported.
- R7: With `pre_i`=0, the first access is at the base. Every handshake reports `wb_valid_o` with the access address plus the step, whatever the value of `wb_en_i`.
- R8: A command with `pre_i`=0 and `wb_en_i`=1 drives `err_o` high for exactly the one cycle after the start. Any other command leaves `err_o` low.
- R9: While `mem_req_o` is high and `mem_rdy_i` is low, `mem_addr_o`, `mem_we_o` and `cur_idx_o` hold their values in the next cycle.
- R10: Every request is four bytes wide. A store drives `mem_be_o`=4'hF, `mem_we_o`=1, and write data equal to `st_data_i` for register `cur_idx_o`. A load drives `mem_be_o`=4'h0 and `mem_we_o`=0.
- R11: A load handshake raises `ld_we_o` in the same cycle, with `ld_idx_o`=`cur_idx_o` and `ld_data_o`=`mem_rdata_i`.
- R12: A load handshake of register 15 raises `br_o` with `br_target_o`=`mem_rdata_i`. Stores and other registers never raise `br_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a command |
| reg_list_i | input | 16 | Selected registers, bit n = register n |
| base_i | input | 32 | Base address |
| load_i | input | 1 | 1 = load, 0 = store |
| pre_i | input | 1 | 1 = step the address before the access |
| up_i | input | 1 | 1 = ascending addresses |
| wb_en_i | input | 1 | Base writeback request |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal post-index writeback flag |
| mem_req_o | output | 1 | Memory request valid |
| mem_rdy_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Request address |
| mem_we_o | output | 1 | 1 = write |
| mem_be_o | output | 4 | Byte strobes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| cur_idx_o | output | 4 | Register being transferred |
| st_data_i | input | 32 | Register file value of `cur_idx_o` |
| ld_we_o | output | 1 | Load result valid |
| ld_idx_o | output | 4 | Load target register |
| ld_data_o | output | 32 | Load result |
| wb_valid_o | output | 1 | Base writeback valid |
| wb_value_o | output | 32 | New base value |
| br_o | output | 1 | Branch request |
| br_target_o | output | 32 | Branch target |

## Verification
The assertions check the following on every cycle:

- A request waiting for ready is held stable.
- The byte strobes match the direction.
- `done_o` is a single pulse inside `busy_o`.
- Branches come only from loads of register 15.
- Consecutive handshakes move downward for loads and upward for stores.

Only the bench scenarios can show the full address sequence, the writeback values for each combination of indexing mode and writeback flag, the skipping of clear bits, the empty-list case, the error pulse, and that a start pulse during a transfer is ignored. The bench shows these by comparing every cycle against its behavioural model, under both an always-ready memory and a slow memory.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_DONE
    } seq_state_e;

    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    input  logic            descend,
    output logic [IW-1:0]   idx
);
    always_comb begin
        idx = '0;
        if (descend) begin
            for (int i = 0; i < NREG; i++)
                if (mask[i]) idx = IW'(i);
        end else begin
            for (int i = NREG - 1; i >= 0; i--)
                if (mask[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic          up,
    input  logic          pre,
    output logic [AW-1:0] acc,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP = AW'(xfer_pkg::WORD_BYTES);

    always_comb begin
        nxt = up ? (cur + STEP) : (cur - STEP);
        acc = pre ? nxt : cur;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned BW  = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] reg_list_i,
    input  logic [AW-1:0]   base_i,
    input  logic            load_i,
    input  logic            pre_i,
    input  logic            up_i,
    input  logic            wb_en_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o,
    output logic            mem_req_o,
    input  logic            mem_rdy_i,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_we_o,
    output logic [BW-1:0]   mem_be_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [IW-1:0]   cur_idx_o,
    input  logic [DW-1:0]   st_data_i,
    output logic            ld_we_o,
    output logic [IW-1:0]   ld_idx_o,
    output logic [DW-1:0]   ld_data_o,
    output logic            wb_valid_o,
    output logic [AW-1:0]   wb_value_o,
    output logic            br_o,
    output logic [DW-1:0]   br_target_o
);
    import xfer_pkg::*;

    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    seq_state_e      state_q, state_d;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q;
    logic            load_q, pre_q, up_q, wb_q, err_q;

    logic [IW-1:0]   pick_idx;
    logic [AW-1:0]   acc_addr, nxt_addr;
    logic [NREG-1:0] pend_after;
    logic            hshake, accept;

    xfer_pick #(.NREG(NREG)) u_pick (
        .mask    (pend_q),
        .descend (load_q),
        .idx     (pick_idx)
    );

    xfer_addr #(.AW(AW)) u_addr (
        .cur (addr_q),
        .up  (up_q),
        .pre (pre_q),
        .acc (acc_addr),
        .nxt (nxt_addr)
    );

    assign accept = (state_q == ST_IDLE) && start_i;
    assign hshake = (state_q == ST_MOVE) && mem_rdy_i;

    always_comb begin
        pend_after = pend_q;
        pend_after[pick_idx] = 1'b0;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (|reg_list_i) ? ST_MOVE : ST_DONE;
            ST_MOVE: if (mem_rdy_i && !(|pend_after)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            load_q <= 1'b0;
            pre_q  <= 1'b0;
            up_q   <= 1'b0;
            wb_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && !pre_i && wb_en_i;
            if (accept) begin
                pend_q <= reg_list_i;
                addr_q <= base_i;
                load_q <= load_i;
                pre_q  <= pre_i;
                up_q   <= up_i;
                wb_q   <= wb_en_i;
            end else if (hshake) begin
                pend_q <= pend_after;
                addr_q <= nxt_addr;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        err_o       = err_q;
        mem_req_o   = (state_q == ST_MOVE);
        mem_addr_o  = acc_addr;
        mem_we_o    = mem_req_o && !load_q;
        mem_be_o    = mem_we_o ? '1 : '0;
        mem_wdata_o = st_data_i;
        cur_idx_o   = pick_idx;
        ld_we_o     = hshake && load_q;
        ld_idx_o    = pick_idx;
        ld_data_o   = mem_rdata_i;
        wb_valid_o  = hshake && (!pre_q || wb_q);
        wb_value_o  = pre_q ? acc_addr : nxt_addr;
        br_o        = ld_we_o && (pick_idx == PC_IDX);
        br_target_o = mem_rdata_i;
    end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 32,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          mem_req_o,
    input logic          mem_rdy_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_we_o,
    input logic [3:0]    mem_be_o,
    input logic [IW-1:0] cur_idx_o,
    input logic          ld_we_o,
    input logic [IW-1:0] ld_idx_o,
    input logic          br_o
);
    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(cur_idx_o)));

    assert_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_be_o == (mem_we_o ? 4'hF : 4'h0)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !mem_req_o) ##1 !done_o);

    assert_branch_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        br_o |-> (ld_we_o && ld_idx_o == IW'(NREG - 1)));

    assert_load_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we_o |=> (!ld_we_o || ld_idx_o < $past(ld_idx_o)));

    assert_store_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i && mem_we_o) |=>
            (!(mem_req_o && mem_rdy_i && mem_we_o) || cur_idx_o > $past(cur_idx_o)));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_rdy_i  (mem_rdy_i),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_be_o   (mem_be_o),
    .cur_idx_o  (cur_idx_o),
    .ld_we_o    (ld_we_o),
    .ld_idx_o   (ld_idx_o),
    .br_o       (br_o)
);

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reg_list_i = '0;
    logic [31:0] base_i = '0;
    logic        load_i = 1'b0, pre_i = 1'b0, up_i = 1'b0, wb_en_i = 1'b0;
    logic        busy_o, done_o, err_o, mem_req_o, mem_we_o;
    logic        mem_rdy_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, st_data_i;
    logic [3:0]  mem_be_o, cur_idx_o, ld_idx_o;
    logic        ld_we_o, wb_valid_o, br_o;
    logic [31:0] ld_data_o, wb_value_o, br_target_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign st_data_i   = 32'hA000_0000 | (32'(cur_idx_o) * 32'h111);
    assign mem_rdata_i = mem_addr_o ^ 32'h5A5A_0000;

    blk_xfer_seq uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Reference queues: register index, access address, writeback value
    logic [3:0]  q_idx[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_wb[$];

    task automatic run_cmd(input logic [15:0] list, input logic [31:0] base,
                           input bit ld, input bit pre, input bit up, input bit wb,
                           input bit slow, input bit poke);
        logic [31:0] cur;
        int n = 0;
        bit rdy;
        cur = base;
        for (int k = 0; k < 16; k++) begin
            int r = ld ? 15 - k : k;
            if (list[r]) begin
                logic [31:0] nx;
                nx = up ? cur + 32'd4 : cur - 32'd4;
                q_idx.push_back(4'(r));
                q_addr.push_back(pre ? nx : cur);
                q_wb.push_back(nx);
                cur = nx;
            end
        end
        @(negedge clk);
        reg_list_i = list; base_i = base; load_i = ld;
        pre_i = pre; up_i = up; wb_en_i = wb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        reg_list_i = 16'hFFFF; base_i = 32'hDEAD_0000; load_i = ~ld; // R2: ignored once busy
        check(err_o == (!pre && wb), "R8 err pulse", 32'(err_o), 32'(!pre && wb));
        forever begin
            rdy = slow ? ((n % 3) == 2) : 1'b1;
            mem_rdy_i = rdy;
            start_i = poke && (n == 1);
            #1;
            check(busy_o == 1'b1, "R2 busy", 32'(busy_o), 32'd1);
            if (q_idx.size() == 0) begin
                check(done_o && !mem_req_o, "R2/R3 done without request",
                      {done_o, mem_req_o}, 32'b10);
                break;
            end
            check(mem_req_o && !done_o, "R4 request present", 32'(mem_req_o), 32'd1);
            check(cur_idx_o == q_idx[0], "R4 register order", 32'(cur_idx_o), 32'(q_idx[0]));
            check(mem_addr_o == q_addr[0], "R5/R6/R7 address", mem_addr_o, q_addr[0]);
            check(mem_we_o == !ld && mem_be_o == (ld ? 4'h0 : 4'hF), "R10 direction/strobes",
                  {mem_we_o, mem_be_o}, {!ld, (ld ? 4'h0 : 4'hF)});
            if (!ld)
                check(mem_wdata_o == (32'hA000_0000 | (32'(q_idx[0]) * 32'h111)),
                      "R10 store data", mem_wdata_o, 32'hA000_0000 | (32'(q_idx[0]) * 32'h111));
            if (rdy) begin
                check(ld_we_o == ld, "R11 load valid", 32'(ld_we_o), 32'(ld));
                if (ld)
                    check(ld_idx_o == q_idx[0] && ld_data_o == (q_addr[0] ^ 32'h5A5A_0000),
                          "R11 load data", ld_data_o, q_addr[0] ^ 32'h5A5A_0000);
                check(br_o == (ld && q_idx[0] == 4'd15), "R12 branch",
                      32'(br_o), 32'(ld && q_idx[0] == 4'd15));
                if (br_o)
                    check(br_target_o == (q_addr[0] ^ 32'h5A5A_0000), "R12 target",
                          br_target_o, q_addr[0] ^ 32'h5A5A_0000);
                check(wb_valid_o == (!pre || wb), "R6/R7 writeback valid",
                      32'(wb_valid_o), 32'(!pre || wb));
                if (wb_valid_o)
                    check(wb_value_o == (pre ? q_addr[0] : q_wb[0]), "R6/R7 writeback value",
                          wb_value_o, pre ? q_addr[0] : q_wb[0]);
                void'(q_idx.pop_front());
                void'(q_addr.pop_front());
                void'(q_wb.pop_front());
            end else begin
                check(!ld_we_o && !wb_valid_o && !br_o, "R9 no effect while waiting",
                      {ld_we_o, wb_valid_o, br_o}, 32'd0);
            end
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        mem_rdy_i = 1'b0;
        start_i = 1'b0;
        #1;
        check(!busy_o && !done_o && !mem_req_o && !err_o, "R2/R8 idle after done",
              {busy_o, done_o, mem_req_o, err_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !done_o && !mem_req_o && !err_o && !ld_we_o && !wb_valid_o,
              "R1 reset state", {busy_o, done_o, mem_req_o, err_o, ld_we_o, wb_valid_o}, 32'd0);
        rst_n = 1'b1;
        run_cmd(16'h8421, 32'h0000_1000, 1, 0, 1, 0, 0, 0); // R7 post-index load, branch
        run_cmd(16'h00F0, 32'h0000_2000, 0, 1, 1, 1, 1, 0); // R6 pre-index store with writeback
        run_cmd(16'hFFFF, 32'h0000_3000, 1, 1, 0, 0, 1, 1); // R5 descending, start poked
        run_cmd(16'h0003, 32'h0000_4000, 0, 0, 0, 1, 0, 0); // R8 illegal combination
        run_cmd(16'h0000, 32'h0000_5000, 1, 0, 1, 0, 0, 0); // R3 empty list
        run_cmd(16'h8001, 32'h0000_6000, 0, 1, 1, 0, 1, 0); // R12 store of 15, no branch
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule